// File: doc/BRIEF.md
# Patchable Outgoing Packet Buffer

This block sits on the transmit side of a frame-level word stream. Each word is 32 bits wide and comes with start-of-frame, end-of-frame and data-enable strobes. The block holds one whole packet in on-chip memory. Upstream logic often learns a length or a checksum only after the header has gone by, so it sends short in-band patch commands once the payload is complete. Each patch names a 16-bit halfword of the stored packet and supplies its new value. Because the upstream layers fix their headers this way, they can share this one buffer instead of each keeping its own.

After the last payload word, the block accepts any number of patch words. It then accepts two trailer words. The first trailer word marks the end of the patches and carries a two-bit error code. The second trailer word is an integrity word that the block passes through unchanged. The block then does one of two things:
- It discards the packet. This happens when the error code asks for a drop or when the packet did not fit in the memory.
- It replays the patched packet on the same kind of interface, followed by the two trailer words.

While it replays a packet, the block holds off its input.

Top module: `pkt_patch_buffer`

## Requirements
- R1: After reset, `in_ready` is 1, and `out_den`, `drop_pulse` and `drop_ovf` are 0.
- R2: No word is emitted while a packet is being accepted. Output starts only after the second trailer word has been taken.
- R3: After the EOF word, an accepted word with bit 15 = 0 is a patch. Bits 31:16 are the new value and bits 14:0 are a halfword offset. The word index is offset[14:1]. Offset bit 0 = 0 selects the low half (bits 15:0) of that word, and 1 selects the high half (bits 31:16).
- R4: Patch words are never emitted. The output is the stored payload words followed by the two trailer words, with `out_den` high on every one of them. `out_sof` is high on the first payload word only, and `out_eof` is high on the last payload word only.
- R5: Several patches to the same offset take effect in arrival order, so the last one wins.
- R6: A patch whose word index is not below the number of stored payload words is ignored.
- R7: The first post-EOF word with bit 15 = 1 is the trailer length word. The next accepted word is the trailer integrity word. Both are emitted unchanged after the payload.
- R8: The error code is bits 13:12 of the trailer length word. For code 11 the packet is discarded: nothing is emitted and `drop_pulse` is high for one cycle. Codes 00, 01 and 10 forward the packet.
- R9: A packet of more than DEPTH (512) payload words is discarded. `drop_pulse` and `drop_ovf` are high together for one cycle. A packet of exactly DEPTH words is forwarded.
- R10: A forwarded packet of N payload words holds `in_ready` low for exactly N+2 cycles. The first output word appears two clock edges after the edge that accepted the integrity word, and the N+2 output words come out back to back.
- R11: While idle, an accepted word without `in_sof` is ignored and produces no output.
- R12: The start-of-frame word of the next packet is accepted in the same cycle that the previous packet's integrity word is presented at the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 32 | Incoming word: payload, patch or trailer |
| in_den | input | 1 | Incoming word valid |
| in_sof | input | 1 | First payload word of a packet |
| in_eof | input | 1 | Last payload word of a packet |
| in_ready | output | 1 | Block can take a word this cycle |
| out_data | output | 32 | Outgoing word |
| out_den | output | 1 | Outgoing word valid |
| out_sof | output | 1 | First outgoing payload word |
| out_eof | output | 1 | Last outgoing payload word |
| drop_pulse | output | 1 | One-cycle pulse when a packet is discarded |
| drop_ovf | output | 1 | One-cycle pulse when the discard is due to overflow |

## Verification
The end of a replay can coincide with the start of intake: the cycle that shows the last trailer word on the output is also the cycle in which the next start-of-frame word can be taken. The bench provokes this by queuing a second packet directly behind the first, so that its first word waits on `in_ready`. It then checks three things:
- the second packet's first word is taken in the same cycle the first packet's integrity word is on the output;
- both packets come out intact;
- the number of stall cycles equals the sum of their lengths plus two each.

// File: rtl/pkb_pkg.sv
package pkb_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD,
    S_PATCH,
    S_CHECK,
    S_DRAIN
  } pkb_state_e;

  localparam logic [1:0] ERR_DROP = 2'b11;

  // post-EOF word: bit 15 low means a patch command
  function automatic logic is_patch_word(input logic [31:0] w);
    return ~w[15];
  endfunction

  // error code carried by the trailer length word
  function automatic logic [1:0] trailer_code(input logic [31:0] w);
    return w[13:12];
  endfunction

  // halfword offset -> word index
  function automatic logic [13:0] patch_word_index(input logic [14:0] off);
    return off[14:1];
  endfunction

endpackage

// File: rtl/pkb_store.sv
module pkb_store #(
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic [1:0]    we,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wd,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data
);

  // one 16-bit lane per halfword so a patch touches only its own half
  for (genvar h = 0; h < 2; h++) begin : g_lane
    logic [15:0] lane_mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we[h]) lane_mem[wr_addr] <= wd[h*16 +: 16];
    end
    assign rd_data[h*16 +: 16] = lane_mem[rd_addr];
  end

endmodule

// File: rtl/pkb_patch_decode.sv
module pkb_patch_decode import pkb_pkg::*; #(
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 2)
) (
  input  logic [15:0]   value_in,
  input  logic [14:0]   offset_in,
  input  logic [CW-1:0] stored_cnt,
  output logic          hit,
  output logic          hi_sel,
  output logic [AW-1:0] widx,
  output logic [15:0]   value
);

  logic [13:0] widx_full;

  always_comb begin
    widx_full = patch_word_index(offset_in);
    hit       = (32'(widx_full) < 32'(stored_cnt));
    hi_sel    = offset_in[0];
    widx      = widx_full[AW-1:0];
    value     = value_in;
  end

endmodule

// File: rtl/pkb_drain.sv
module pkb_drain #(
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] stored_cnt,
  input  logic [31:0]   tlen,
  input  logic [31:0]   tcrc,
  input  logic [31:0]   rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          done,
  output logic [31:0]   out_data,
  output logic          out_den,
  output logic          out_sof,
  output logic          out_eof
);

  logic          busy;
  logic [CW-1:0] idx;

  assign rd_addr = idx[AW-1:0];
  assign done    = busy && (idx == stored_cnt + CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy) begin
      idx <= idx + CW'(1);
      if (done) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_data <= '0;
      out_den  <= 1'b0;
      out_sof  <= 1'b0;
      out_eof  <= 1'b0;
    end else begin
      out_den <= busy;
      out_sof <= busy && (idx == '0);
      out_eof <= busy && (idx == stored_cnt - CW'(1));
      if (!busy)                 out_data <= '0;
      else if (idx < stored_cnt) out_data <= rd_data;
      else if (idx == stored_cnt) out_data <= tlen;
      else                       out_data <= tcrc;
    end
  end

endmodule

// File: rtl/pkt_patch_buffer.sv
module pkt_patch_buffer import pkb_pkg::*; #(
  parameter int DEPTH = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] in_data,
  input  logic        in_den,
  input  logic        in_sof,
  input  logic        in_eof,
  output logic        in_ready,
  output logic [31:0] out_data,
  output logic        out_den,
  output logic        out_sof,
  output logic        out_eof,
  output logic        drop_pulse,
  output logic        drop_ovf
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 2);

  pkb_state_e    state;
  logic [CW-1:0] count;
  logic          ovf;
  logic [31:0]   tlen, tcrc;

  // named internal events
  logic accept, full, is_upd;
  logic store_fire, upd_fire, trailer_fire, check_fire;
  logic discard_now, start_drain, drain_done, draining;

  logic          p_hit, p_hi;
  logic [AW-1:0] p_widx;
  logic [15:0]   p_value;
  logic [1:0]    we;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [31:0]   wd, rd_data;

  assign in_ready = (state != S_DRAIN);
  assign draining = (state == S_DRAIN);
  assign accept   = in_den && in_ready;
  assign full     = (count == CW'(DEPTH));
  assign is_upd   = is_patch_word(in_data);

  pkb_patch_decode #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_dec (
    .value_in  (in_data[31:16]),
    .offset_in (in_data[14:0]),
    .stored_cnt(count),
    .hit       (p_hit),
    .hi_sel    (p_hi),
    .widx      (p_widx),
    .value     (p_value)
  );

  always_comb begin
    store_fire   = accept && (((state == S_IDLE) && in_sof) ||
                              ((state == S_LOAD) && !full));
    upd_fire     = accept && (state == S_PATCH) && is_upd && !ovf && p_hit;
    trailer_fire = accept && (state == S_PATCH) && !is_upd;
    check_fire   = accept && (state == S_CHECK);
    discard_now  = check_fire && (ovf || (trailer_code(tlen) == ERR_DROP));
    start_drain  = check_fire && !discard_now;

    unique case (state)
      S_IDLE:  wr_addr = '0;
      S_LOAD:  wr_addr = count[AW-1:0];
      default: wr_addr = p_widx;
    endcase
    we[0] = store_fire || (upd_fire && !p_hi);
    we[1] = store_fire || (upd_fire && p_hi);
    wd    = store_fire ? in_data : {p_value, p_value};
  end

  pkb_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk    (clk),
    .we     (we),
    .wr_addr(wr_addr),
    .wd     (wd),
    .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  pkb_drain #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_drain (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_drain),
    .stored_cnt(count),
    .tlen      (tlen),
    .tcrc      (tcrc),
    .rd_data   (rd_data),
    .rd_addr   (rd_addr),
    .done      (drain_done),
    .out_data  (out_data),
    .out_den   (out_den),
    .out_sof   (out_sof),
    .out_eof   (out_eof)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      count      <= '0;
      ovf        <= 1'b0;
      tlen       <= '0;
      tcrc       <= '0;
      drop_pulse <= 1'b0;
      drop_ovf   <= 1'b0;
    end else begin
      drop_pulse <= discard_now;
      drop_ovf   <= discard_now && ovf;
      unique case (state)
        S_IDLE: if (accept && in_sof) begin
          count <= CW'(1);
          ovf   <= 1'b0;
          state <= in_eof ? S_PATCH : S_LOAD;
        end
        S_LOAD: if (accept) begin
          if (!full) count <= count + CW'(1);
          else       ovf   <= 1'b1;
          if (in_eof) state <= S_PATCH;
        end
        S_PATCH: if (trailer_fire) begin
          tlen  <= in_data;
          state <= S_CHECK;
        end
        S_CHECK: if (check_fire) begin
          tcrc  <= in_data;
          state <= discard_now ? S_IDLE : S_DRAIN;
        end
        S_DRAIN: if (drain_done) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pkb_checker.sv
module pkb_checker (
  input logic clk,
  input logic rst_n,
  input logic out_den,
  input logic out_sof,
  input logic out_eof,
  input logic drop_pulse,
  input logic drop_ovf,
  input logic draining,
  input logic upd_fire
);

  // R2: output only follows a cycle spent draining
  assert_out_after_drain_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_den |-> $past(draining));

  // R4: every burst opens with the start-of-frame word
  assert_burst_opens_sof_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_den) |-> out_sof);

  // R7: a trailer word follows the last payload word
  assert_trailer_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |=> (out_den && !out_sof && !out_eof));

  // R8: a discard never coincides with output
  assert_drop_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drop_pulse |-> !out_den);

  // R9: overflow flag only accompanies a discard
  assert_ovf_with_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    drop_ovf |-> drop_pulse);

  // R3: patches are applied while nothing is on the output
  assert_patch_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_fire |-> !out_den);

endmodule

bind pkt_patch_buffer pkb_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_den   (out_den),
  .out_sof   (out_sof),
  .out_eof   (out_eof),
  .drop_pulse(drop_pulse),
  .drop_ovf  (drop_ovf),
  .draining  (draining),
  .upd_fire  (upd_fire)
);

// File: tb/tb_pkt_patch_buffer.sv
module tb_pkt_patch_buffer;

  localparam int DEPTH = 512;
  localparam int MAXW  = 1300;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_den = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic        in_ready, out_den, out_sof, out_eof, drop_pulse, drop_ovf;
  logic [31:0] out_data;

  always #5 clk = ~clk;

  pkt_patch_buffer #(.DEPTH(DEPTH)) dut (.*);

  int total = 0, bad = 0, cyc = 0;

  // stimulus stream and expected output
  logic [31:0] st_d [MAXW];
  logic        st_s [MAXW];
  logic        st_e [MAXW];
  int          st_c [MAXW];
  int          nst = 0;
  logic [31:0] ex_d [MAXW];
  logic        ex_s [MAXW];
  logic        ex_e [MAXW];
  int          nex = 0;
  int          pk_chk [8];
  int          pk_out [8];
  int          npk = 0;
  int          exp_drop = 0, exp_ovf = 0, exp_stall = 0;
  logic [31:0] upd_w [8];

  // capture
  logic [31:0] cap_d [MAXW];
  logic        cap_s [MAXW];
  logic        cap_e [MAXW];
  int          cap_c [MAXW];
  int          ncap = 0, ndrop = 0, novf = 0, nstall = 0;

  // patch vector table: payload length, offset, patched word index, expected word
  localparam int          VN = 6;
  localparam int          V_LEN [VN] = '{4, 4, 4, 1, 4, 8};
  localparam logic [14:0] V_OFF [VN] = '{15'd0, 15'd1, 15'd7, 15'd1, 15'd8, 15'd15};
  localparam int          V_IDX [VN] = '{0, 0, 3, 0, 3, 7};
  localparam logic [31:0] V_EXP [VN] = '{32'h1100BEEF, 32'hBEEF2200, 32'hBEEF2203,
                                         32'hBEEF2200, 32'h11032203, 32'hBEEF2207};

  always_ff @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_den && ncap < MAXW) begin
        cap_d[ncap] = out_data; cap_s[ncap] = out_sof;
        cap_e[ncap] = out_eof;  cap_c[ncap] = cyc;
        ncap++;
      end
      if (drop_pulse) ndrop++;
      if (drop_ovf)   novf++;
      if (!in_ready)  nstall++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pay(input int i);
    return {16'h1100 + i[15:0], 16'h2200 + i[15:0]};
  endfunction

  task automatic clear_stream();
    nst = 0; nex = 0; npk = 0; exp_drop = 0; exp_ovf = 0; exp_stall = 0;
  endtask

  task automatic push(input logic [31:0] d, input logic s, input logic e);
    st_d[nst] = d; st_s[nst] = s; st_e[nst] = e; nst++;
  endtask

  // append a packet and its independently computed expected output
  task automatic add_pkt(input int len, input int nu, input logic [31:0] tl, input logic [31:0] tc);
    logic [31:0] m [MAXW];
    bit drop;
    for (int i = 0; i < len; i++) begin
      m[i] = pay(i);
      push(pay(i), i == 0, i == len - 1);
    end
    for (int u = 0; u < nu; u++) begin
      int wi;
      push(upd_w[u], 1'b0, 1'b0);
      wi = int'(upd_w[u][14:0]) / 2;
      if (wi < len && len <= DEPTH) begin
        if (upd_w[u][0]) m[wi][31:16] = upd_w[u][31:16];
        else             m[wi][15:0]  = upd_w[u][31:16];
      end
    end
    push(tl, 1'b0, 1'b0);
    pk_chk[npk] = nst;
    push(tc, 1'b0, 1'b0);
    drop = (tl[13:12] == 2'b11) || (len > DEPTH);
    if (drop) begin
      exp_drop++;
      if (len > DEPTH) exp_ovf++;
    end else begin
      pk_out[npk] = nex;
      npk++;
      for (int i = 0; i < len; i++) begin
        ex_d[nex] = m[i]; ex_s[nex] = (i == 0); ex_e[nex] = (i == len - 1); nex++;
      end
      ex_d[nex] = tl; ex_s[nex] = 0; ex_e[nex] = 0; nex++;
      ex_d[nex] = tc; ex_s[nex] = 0; ex_e[nex] = 0; nex++;
      exp_stall += len + 2;
    end
  endtask

  task automatic run_stream(input string tag);
    @(posedge clk);
    ncap = 0; ndrop = 0; novf = 0; nstall = 0;
    for (int i = 0; i < nst; i++) begin
      @(negedge clk);
      in_data = st_d[i]; in_sof = st_s[i]; in_eof = st_e[i]; in_den = 1'b1;
      while (!in_ready) @(negedge clk);
      st_c[i] = cyc;
      @(posedge clk);
    end
    @(negedge clk);
    in_den = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    repeat (4) @(negedge clk);
    while (!in_ready) @(negedge clk);
    repeat (4) @(negedge clk);
    // R4 R7: output word count and contents; R8 R9: discards
    chk(ncap == nex, {"R4 word count ", tag}, ncap, nex);
    for (int i = 0; i < nex && i < ncap; i++) begin
      chk(cap_d[i] == ex_d[i], {"R4 R7 data ", tag}, cap_d[i], ex_d[i]);
      chk(cap_s[i] == ex_s[i] && cap_e[i] == ex_e[i], {"R4 sof/eof ", tag},
          {cap_s[i], cap_e[i]}, {ex_s[i], ex_e[i]});
    end
    chk(ndrop == exp_drop, {"R8 drop count ", tag}, ndrop, exp_drop);
    chk(novf == exp_ovf, {"R9 ovf count ", tag}, novf, exp_ovf);
    chk(nstall == exp_stall, {"R10 stall cycles ", tag}, nstall, exp_stall);
    // R10: latency and contiguity of each forwarded packet
    for (int p = 0; p < npk; p++) begin
      if (pk_out[p] < ncap)
        chk(cap_c[pk_out[p]] == st_c[pk_chk[p]] + 2, {"R10 latency ", tag},
            cap_c[pk_out[p]], st_c[pk_chk[p]] + 2);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL R10 watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(in_ready == 1'b1, "R1 in_ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_den == 1'b0, "R1 idle after reset", {in_ready, out_den}, 2'b10);
    chk(drop_pulse == 1'b0 && drop_ovf == 1'b0, "R1 no drop after reset", {drop_pulse, drop_ovf}, 0);

    // R3 R6: table of single patches
    for (int v = 0; v < VN; v++) begin
      clear_stream();
      upd_w[0] = {16'hBEEF, 1'b0, V_OFF[v]};
      add_pkt(V_LEN[v], 1, 32'h0012_8000 + v, 32'hC0DE_0000 + v);
      run_stream("table");
      chk(cap_d[V_IDX[v]] == V_EXP[v], (v == 4) ? "R6 out-of-range patch ignored" : "R3 patched halfword",
          cap_d[V_IDX[v]], V_EXP[v]);
    end

    // R5: repeated offset, last wins
    clear_stream();
    upd_w[0] = {16'h1111, 1'b0, 15'd2};
    upd_w[1] = {16'h2222, 1'b0, 15'd2};
    upd_w[2] = {16'h3333, 1'b0, 15'd5};
    add_pkt(3, 3, 32'h0000_8000, 32'h5555_AAAA);
    run_stream("repeat");
    chk(cap_d[1] == 32'h11012222, "R5 last patch wins", cap_d[1], 32'h11012222);
    chk(cap_d[2] == 32'h33332202, "R5 high half patch", cap_d[2], 32'h33332202);

    // R11: stray idle words, then a packet with no patches
    clear_stream();
    push(32'hDEAD_BEEF, 1'b0, 1'b0);
    push(32'h0000_8000, 1'b0, 1'b1);
    add_pkt(2, 0, 32'h0001_8000, 32'h0BAD_F00D);
    run_stream("R11 idle garbage");
    chk(cap_d[0] == pay(0), "R11 stray words ignored", cap_d[0], pay(0));

    // R8: drop code and reserved codes
    clear_stream();
    add_pkt(3, 0, 32'h0000_B000, 32'h1);
    run_stream("R8 drop");
    chk(ncap == 0, "R8 dropped packet silent", ncap, 0);
    clear_stream();
    add_pkt(2, 0, 32'h0000_9000, 32'h2);
    add_pkt(2, 0, 32'h0000_A000, 32'h3);
    run_stream("R8 reserved codes");

    // R9: overflow, then exactly full, then recovery
    clear_stream();
    upd_w[0] = {16'h7777, 1'b0, 15'd0};
    add_pkt(DEPTH + 1, 1, 32'h0000_8000, 32'h4);
    add_pkt(2, 0, 32'h0000_8000, 32'h5);
    run_stream("R9 overflow");
    clear_stream();
    add_pkt(DEPTH, 0, 32'h0000_8000, 32'h6);
    run_stream("R9 exactly full");

    // R12 R10: back-to-back packets
    clear_stream();
    add_pkt(3, 0, 32'h0000_8003, 32'hAAAA_0001);
    add_pkt(2, 0, 32'h0000_8002, 32'hAAAA_0002);
    run_stream("R12 back-to-back");
    if (ncap >= 5)
      chk(cap_c[4] == st_c[pk_chk[0] + 1], "R12 sof taken with last trailer out",
          cap_c[4], st_c[pk_chk[0] + 1]);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule